// File: doc/BRIEF.md
# PUF-Keyed Secure Boot Sequencer

This block is the control state machine that brings up a device whose root key is derived from a physical unclonable function built into its enclosure. After reset it requests a measurement of the enclosure response. It then requests a key derived from that response and uses the key to have a crypto engine decrypt the stored bootloader image. A successful decrypt proves that the enclosure is intact. The bootloader is then released and the sequencer waits for the result of the firmware signature check.

A failed decrypt has two possible causes: a breached enclosure or a first power-up. A one-time-programmable provisioned flag separates the two cases. If the flag is set, the sequencer enters a terminal tamper lock and never releases the bootloader. If the flag is clear, the sequencer has the crypto engine encrypt and store the image under the new key. It then pulses a write request to program the flag and continues with the release.

Every outside engine is reached through a request/done/status handshake. The request is held high until done arrives. A per-step watchdog turns a missing done into a failure of that step.

Top module: `pboot_seq`

## Requirements
- R1: A synchronous reset places the block in the measurement phase with status 0. The measurement request is high. All other requests, the release, the flag write, the key valid strobe, the lock output and the key output are low or zero.
- R2: At most one engine request is high at any time. Requests are issued strictly in this order: measurement, key derivation, decrypt, then (only on a first boot) encrypt-and-store, then bootloader release.
- R3: A successful decrypt leads directly to the bootloader release, with no encrypt request and no flag write.
- R4: A failed decrypt (status low or timeout) with the provisioned flag high enters the tamper lock. In the lock, status is 7 and the lock output is high. No request is made, the bootloader is never released, and the lock holds until reset.
- R5: A failed decrypt with the provisioned flag low issues the encrypt-and-store request. If that succeeds, the flag write is pulsed for exactly one cycle and the release follows in the next cycle.
- R6: A failed or timed-out encrypt-and-store halts the boot with status 6 and no flag write.
- R7: A failed or timed-out measurement or key derivation halts the boot with status 6, and no decrypt is requested.
- R8: A passing signature check gives status 5 with the release held high. A failing or timed-out signature check gives status 6 with the release low and the lock output low.
- R9: Each request is held for at most TMO_CYC cycles. A done seen in the TMO_CYC-th cycle of a step is still accepted. A step without a done in that window fails.
- R10: The key valid strobe is high only while the decrypt or encrypt request is high. During that time the key output equals the key captured when derivation completed. Otherwise the key output is zero.
- R11: The status codes are: 0 measuring, 1 deriving, 2 decrypting, 3 provisioning, 4 awaiting signature, 5 operational, 6 halted, 7 tamper lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prov_flag | input | 1 | One-time-programmable provisioned flag |
| meas_req | output | 1 | Enclosure response measurement request |
| meas_done | input | 1 | Measurement finished |
| meas_ok | input | 1 | Measurement status |
| kdf_req | output | 1 | Key derivation request |
| kdf_done | input | 1 | Key derivation finished |
| kdf_ok | input | 1 | Key derivation status |
| kdf_key | input | KEY_W | Derived key, valid with kdf_done |
| dec_req | output | 1 | Bootloader decrypt request |
| dec_done | input | 1 | Decrypt finished |
| dec_ok | input | 1 | Decrypt authenticated successfully |
| enc_req | output | 1 | Encrypt-and-store request (first boot) |
| enc_done | input | 1 | Encrypt-and-store finished |
| enc_ok | input | 1 | Encrypt-and-store status |
| prov_wr | output | 1 | One-cycle request to program the provisioned flag |
| key_out | output | KEY_W | Key presented to the crypto engine |
| key_valid | output | 1 | Key output is valid |
| boot_release | output | 1 | Bootloader released to run |
| sig_done | input | 1 | Signature check finished |
| sig_ok | input | 1 | Signature check passed |
| status | output | 3 | Phase code |
| tamper_lock | output | 1 | Terminal tamper lock |

## Verification
Some properties are checked by assertions on every cycle. At most one request is active. The key is gated to the crypto phases and is zero elsewhere. No request is longer than the watchdog window. The lock is sticky and never coexists with a request or a release. The flag write is a single pulse that occurs only while the flag is clear and is followed by the release. Other behaviour can only be shown by the bench scenarios. These cover the exact order of requests for each path through the sequence, the choice between lock and provisioning after a failed decrypt, halting on every step's failure, and acceptance of a done in the last cycle of the window versus failure after a silent engine.

// File: rtl/pboot_pkg.sv
package pboot_pkg;

  typedef enum logic [3:0] {
    ST_MEAS, ST_KDF, ST_DEC, ST_ENC, ST_FLAG,
    ST_SIG, ST_RUN, ST_HALT, ST_LOCK
  } pb_state_e;

  localparam logic [2:0] CODE_MEAS = 3'd0;
  localparam logic [2:0] CODE_KDF  = 3'd1;
  localparam logic [2:0] CODE_DEC  = 3'd2;
  localparam logic [2:0] CODE_PROV = 3'd3;
  localparam logic [2:0] CODE_SIG  = 3'd4;
  localparam logic [2:0] CODE_RUN  = 3'd5;
  localparam logic [2:0] CODE_HALT = 3'd6;
  localparam logic [2:0] CODE_LOCK = 3'd7;

endpackage

// File: rtl/pboot_wdog.sv
module pboot_wdog #(
  parameter int TMO_CYC = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pboot_keyreg.sv
module pboot_keyreg #(
  parameter int KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             hold,
  input  logic [KEY_W-1:0] din,
  output logic [KEY_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= din;
    end else if (!hold) begin
      q <= '0;
    end
  end
endmodule

// File: rtl/pboot_stat.sv
module pboot_stat
  import pboot_pkg::*;
(
  input  pb_state_e  st,
  output logic [2:0] code
);
  always_comb begin
    unique case (st)
      ST_MEAS:         code = CODE_MEAS;
      ST_KDF:          code = CODE_KDF;
      ST_DEC:          code = CODE_DEC;
      ST_ENC, ST_FLAG: code = CODE_PROV;
      ST_SIG:          code = CODE_SIG;
      ST_RUN:          code = CODE_RUN;
      ST_LOCK:         code = CODE_LOCK;
      default:         code = CODE_HALT;
    endcase
  end
endmodule

// File: rtl/pboot_seq.sv
module pboot_seq
  import pboot_pkg::*;
#(
  parameter int KEY_W   = 128,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prov_flag,
  output logic             meas_req,
  input  logic             meas_done,
  input  logic             meas_ok,
  output logic             kdf_req,
  input  logic             kdf_done,
  input  logic             kdf_ok,
  input  logic [KEY_W-1:0] kdf_key,
  output logic             dec_req,
  input  logic             dec_done,
  input  logic             dec_ok,
  output logic             enc_req,
  input  logic             enc_done,
  input  logic             enc_ok,
  output logic             prov_wr,
  output logic [KEY_W-1:0] key_out,
  output logic             key_valid,
  output logic             boot_release,
  input  logic             sig_done,
  input  logic             sig_ok,
  output logic [2:0]       status,
  output logic             tamper_lock
);
  pb_state_e  state_q, state_d;
  logic       tmo;
  logic [2:0] code_d;
  logic       key_load, key_hold;

  pboot_wdog #(.TMO_CYC(TMO_CYC)) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .restart (state_d != state_q),
    .expired (tmo)
  );

  pboot_stat u_stat (
    .st   (state_d),
    .code (code_d)
  );

  assign key_hold = (state_d == ST_DEC) || (state_d == ST_ENC);
  assign key_load = (state_q == ST_KDF) && (state_d == ST_DEC);

  pboot_keyreg #(.KEY_W(KEY_W)) u_key (
    .clk  (clk),
    .rst  (rst),
    .load (key_load),
    .hold (key_hold),
    .din  (kdf_key),
    .q    (key_out)
  );

  // Next phase: each wait state leaves on done or on watchdog expiry
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_MEAS: begin
        if (meas_done)  state_d = meas_ok ? ST_KDF : ST_HALT;
        else if (tmo)   state_d = ST_HALT;
      end
      ST_KDF: begin
        if (kdf_done)   state_d = kdf_ok ? ST_DEC : ST_HALT;
        else if (tmo)   state_d = ST_HALT;
      end
      ST_DEC: begin
        if (dec_done && dec_ok)  state_d = ST_SIG;
        else if (dec_done || tmo) state_d = prov_flag ? ST_LOCK : ST_ENC;
      end
      ST_ENC: begin
        if (enc_done)   state_d = enc_ok ? ST_FLAG : ST_HALT;
        else if (tmo)   state_d = ST_HALT;
      end
      ST_FLAG:          state_d = ST_SIG;
      ST_SIG: begin
        if (sig_done)   state_d = sig_ok ? ST_RUN : ST_HALT;
        else if (tmo)   state_d = ST_HALT;
      end
      default:          state_d = state_q;
    endcase
  end

  // Outputs registered from the next phase so they line up with state_q
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_MEAS;
      meas_req     <= 1'b1;
      kdf_req      <= 1'b0;
      dec_req      <= 1'b0;
      enc_req      <= 1'b0;
      prov_wr      <= 1'b0;
      key_valid    <= 1'b0;
      boot_release <= 1'b0;
      tamper_lock  <= 1'b0;
      status       <= CODE_MEAS;
    end else begin
      state_q      <= state_d;
      meas_req     <= (state_d == ST_MEAS);
      kdf_req      <= (state_d == ST_KDF);
      dec_req      <= (state_d == ST_DEC);
      enc_req      <= (state_d == ST_ENC);
      prov_wr      <= (state_d == ST_FLAG);
      key_valid    <= key_hold;
      boot_release <= (state_d == ST_SIG) || (state_d == ST_RUN);
      tamper_lock  <= (state_d == ST_LOCK);
      status       <= code_d;
    end
  end
endmodule

// File: rtl/pboot_seq_chk.sv
module pboot_seq_chk #(
  parameter int KEY_W   = 128,
  parameter int TMO_CYC = 4096
) (
  input logic             clk,
  input logic             rst,
  input logic             prov_flag,
  input logic             meas_req,
  input logic             kdf_req,
  input logic             dec_req,
  input logic             enc_req,
  input logic             prov_wr,
  input logic [KEY_W-1:0] key_out,
  input logic             key_valid,
  input logic             boot_release,
  input logic [2:0]       status,
  input logic             tamper_lock
);
  localparam int RW = $clog2(TMO_CYC + 2) + 1;

  logic [4:0]    req_vec, req_prev;
  logic [RW-1:0] run_len;

  assign req_vec = {meas_req, kdf_req, dec_req, enc_req,
                    boot_release && (status == 3'd4)};

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= '0;
      run_len  <= '0;
    end else begin
      req_prev <= req_vec;
      if (req_vec == '0)           run_len <= '0;
      else if (req_vec != req_prev) run_len <= RW'(1);
      else if (run_len != '1)      run_len <= run_len + 1'b1;
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    $countones({meas_req, kdf_req, dec_req, enc_req}) <= 1); // R2
  AST_KEY_GATED: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (dec_req || enc_req)); // R10
  AST_KEY_ZERO: assert property (@(posedge clk) disable iff (rst)
    !key_valid |-> (key_out == '0)); // R10
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    tamper_lock |=> tamper_lock); // R4
  AST_LOCK_QUIET: assert property (@(posedge clk) disable iff (rst)
    tamper_lock |-> !(boot_release || meas_req || kdf_req || dec_req || enc_req)); // R4
  AST_LOCK_CODE: assert property (@(posedge clk) disable iff (rst)
    tamper_lock |-> (status == 3'd7)); // R11
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    prov_wr |=> (!prov_wr && boot_release)); // R5
  AST_WR_UNPROV: assert property (@(posedge clk) disable iff (rst)
    prov_wr |-> !prov_flag); // R5
  AST_RUN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (status == 3'd5) |-> boot_release); // R8
  AST_REQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_len <= RW'(TMO_CYC)); // R9
endmodule

bind pboot_seq pboot_seq_chk #(.KEY_W(KEY_W), .TMO_CYC(TMO_CYC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .prov_flag    (prov_flag),
  .meas_req     (meas_req),
  .kdf_req      (kdf_req),
  .dec_req      (dec_req),
  .enc_req      (enc_req),
  .prov_wr      (prov_wr),
  .key_out      (key_out),
  .key_valid    (key_valid),
  .boot_release (boot_release),
  .status       (status),
  .tamper_lock  (tamper_lock)
);

// File: tb/pboot_seq_bench.sv
`timescale 1ns/1ps

module pboot_seq_eng (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [10:0] dly,
  output logic        done
);
  logic [10:0] cnt;
  always @(negedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req && !done) begin
        if (cnt == dly) begin
          done <= 1'b1;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

module pboot_seq_bench;
  localparam int KEY_W   = 32;
  localparam int TMO_CYC = 16;
  localparam logic [KEY_W-1:0] KEY = 32'hC0DE_5EED;
  localparam logic [10:0] HANG = 11'd2000;

  typedef struct packed {
    logic        prov;
    logic [4:0]  okm;   // [0] meas [1] kdf [2] dec [3] enc [4] sig
    logic [2:0]  hang;  // 0 none, 1 meas, 2 kdf, 3 dec, 4 enc, 5 sig
    logic [3:0]  dly;
    logic [23:0] seq;   // request order: 1 meas 2 kdf 3 dec 4 enc 5 release
    logic [2:0]  fin;
    logic        pw;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'b11111, 3'd0, 4'd0,  24'h001235, 3'd5, 1'b0},
    '{1'b1, 5'b11011, 3'd0, 4'd2,  24'h000123, 3'd7, 1'b0},
    '{1'b0, 5'b11011, 3'd0, 4'd3,  24'h012345, 3'd5, 1'b1},
    '{1'b0, 5'b10011, 3'd0, 4'd1,  24'h001234, 3'd6, 1'b0},
    '{1'b1, 5'b01111, 3'd0, 4'd4,  24'h001235, 3'd6, 1'b0},
    '{1'b1, 5'b11110, 3'd0, 4'd0,  24'h000001, 3'd6, 1'b0},
    '{1'b1, 5'b11101, 3'd0, 4'd2,  24'h000012, 3'd6, 1'b0},
    '{1'b1, 5'b11111, 3'd3, 4'd1,  24'h000123, 3'd7, 1'b0},
    '{1'b0, 5'b11111, 3'd0, 4'd0,  24'h001235, 3'd5, 1'b0},
    '{1'b1, 5'b11111, 3'd5, 4'd0,  24'h001235, 3'd6, 1'b0},
    '{1'b1, 5'b11111, 3'd1, 4'd0,  24'h000001, 3'd6, 1'b0},
    '{1'b1, 5'b11111, 3'd0, 4'd15, 24'h001235, 3'd5, 1'b0},
    '{1'b0, 5'b11011, 3'd4, 4'd2,  24'h001234, 3'd6, 1'b0},
    '{1'b0, 5'b11111, 3'd3, 4'd0,  24'h012345, 3'd5, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prov_flag = 1'b0;
  logic meas_ok = 1'b0, kdf_ok = 1'b0, dec_ok = 1'b0, enc_ok = 1'b0, sig_ok = 1'b0;
  logic [10:0] d_meas = HANG, d_kdf = HANG, d_dec = HANG, d_enc = HANG, d_sig = HANG;
  logic meas_req, kdf_req, dec_req, enc_req, prov_wr, key_valid, boot_release, tamper_lock;
  logic meas_done, kdf_done, dec_done, enc_done, sig_done;
  logic [KEY_W-1:0] key_out;
  logic [2:0] status;
  logic sig_wait;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign sig_wait = boot_release && (status == 3'd4);

  pboot_seq #(.KEY_W(KEY_W), .TMO_CYC(TMO_CYC)) u_pboot_seq (
    .clk(clk), .rst(rst), .prov_flag(prov_flag),
    .meas_req(meas_req), .meas_done(meas_done), .meas_ok(meas_ok),
    .kdf_req(kdf_req), .kdf_done(kdf_done), .kdf_ok(kdf_ok), .kdf_key(KEY),
    .dec_req(dec_req), .dec_done(dec_done), .dec_ok(dec_ok),
    .enc_req(enc_req), .enc_done(enc_done), .enc_ok(enc_ok),
    .prov_wr(prov_wr), .key_out(key_out), .key_valid(key_valid),
    .boot_release(boot_release), .sig_done(sig_done), .sig_ok(sig_ok),
    .status(status), .tamper_lock(tamper_lock)
  );

  pboot_seq_eng u_e_meas (.clk(clk), .rst(rst), .req(meas_req), .dly(d_meas), .done(meas_done));
  pboot_seq_eng u_e_kdf  (.clk(clk), .rst(rst), .req(kdf_req),  .dly(d_kdf),  .done(kdf_done));
  pboot_seq_eng u_e_dec  (.clk(clk), .rst(rst), .req(dec_req),  .dly(d_dec),  .done(dec_done));
  pboot_seq_eng u_e_enc  (.clk(clk), .rst(rst), .req(enc_req),  .dly(d_enc),  .done(enc_done));
  pboot_seq_eng u_e_sig  (.clk(clk), .rst(rst), .req(sig_wait), .dly(d_sig),  .done(sig_done));

  // Observers: request order, flag writes, key rule breaches, decrypt request length
  logic [23:0] hist;
  logic p_m, p_k, p_d, p_e, p_r;
  int n_wr, n_kerr, n_dcyc;

  always @(negedge clk) begin
    if (rst) begin
      hist <= '0; p_m <= 1'b0; p_k <= 1'b0; p_d <= 1'b0; p_e <= 1'b0; p_r <= 1'b0;
      n_wr <= 0; n_kerr <= 0; n_dcyc <= 0;
    end else begin
      p_m <= meas_req; p_k <= kdf_req; p_d <= dec_req; p_e <= enc_req; p_r <= boot_release;
      if (meas_req && !p_m)          hist <= {hist[19:0], 4'h1};
      else if (kdf_req && !p_k)      hist <= {hist[19:0], 4'h2};
      else if (dec_req && !p_d)      hist <= {hist[19:0], 4'h3};
      else if (enc_req && !p_e)      hist <= {hist[19:0], 4'h4};
      else if (boot_release && !p_r) hist <= {hist[19:0], 4'h5};
      if (prov_wr) n_wr <= n_wr + 1;
      if (dec_req) n_dcyc <= n_dcyc + 1;
      if ((key_valid && (key_out != KEY || !(dec_req || enc_req))) ||
          (!key_valid && key_out != '0))
        n_kerr <= n_kerr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.hang != 0)                          return "R9";
    if (!v.okm[0] || !v.okm[1])               return "R7";
    if (v.fin == 3'd7)                        return "R4";
    if (!v.prov && !v.okm[2] && !v.okm[3])    return "R6";
    if (v.pw)                                 return "R5";
    if (!v.okm[4])                            return "R8";
    return "R3";
  endfunction

  task automatic run_vec(input vec_t v);
    logic [2:0] s1;
    string t;
    t = tag_of(v);
    rst = 1'b1;
    prov_flag = v.prov;
    {sig_ok, enc_ok, dec_ok, kdf_ok, meas_ok} = v.okm;
    d_meas = (v.hang == 3'd1) ? HANG : 11'(v.dly);
    d_kdf  = (v.hang == 3'd2) ? HANG : 11'(v.dly);
    d_dec  = (v.hang == 3'd3) ? HANG : 11'(v.dly);
    d_enc  = (v.hang == 3'd4) ? HANG : 11'(v.dly);
    d_sig  = (v.hang == 3'd5) ? HANG : 11'(v.dly);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (status >= 3'd5) break;
    end
    repeat (10) @(negedge clk);
    s1 = status;
    chk(status == v.fin, {t, " R11 final status"}, 32'(status), 32'(v.fin));
    chk(hist == v.seq, {t, " R2 request order"}, 32'(hist), 32'(v.seq));
    chk(n_wr == int'(v.pw), "R5 flag write count", 32'(n_wr), 32'(v.pw));
    chk(tamper_lock == (v.fin == 3'd7), "R4 lock output", 32'(tamper_lock), 32'(v.fin == 3'd7));
    chk(boot_release == (v.fin == 3'd5), "R8 release level", 32'(boot_release), 32'(v.fin == 3'd5));
    chk(n_kerr == 0, "R10 key gating", 32'(n_kerr), 32'd0);
    if (v.hang == 3'd3)
      chk(n_dcyc == TMO_CYC, "R9 decrypt window", 32'(n_dcyc), 32'(TMO_CYC));
    repeat (20) @(negedge clk);
    chk(status == s1 && !(meas_req || kdf_req || dec_req || enc_req),
        {t, " R4 terminal phase stable"}, 32'(status), 32'(s1));
  endtask

  initial begin
    // Directed: reset state with a silent measurement unit (R1)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 3'd0 && meas_req, "R1 reset phase", 32'(status), 32'd0);
    chk(!(kdf_req || dec_req || enc_req || prov_wr || key_valid || boot_release || tamper_lock)
        && key_out == '0, "R1 reset outputs quiet",
        32'({kdf_req, dec_req, enc_req, prov_wr, key_valid, boot_release, tamper_lock}), 32'd0);
    repeat (TMO_CYC + 2) @(negedge clk);
    chk(status == 3'd6, "R9 R7 measurement timeout halts", 32'(status), 32'd6);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // Directed: reset leaves the tamper lock (R1)
    run_vec(VECS[1]);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status == 3'd0 && !tamper_lock, "R1 reset clears lock phase", 32'(status), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule